// File: doc/BRIEF.md
# Serial Control Word Loader

This block receives configuration words over a three-wire serial link: a serial clock, a serial data line and a latch-enable strobe. Bits are shifted in most significant first on each rising edge of the serial clock. When latch-enable rises, the final bit shifted in acts as a routing flag and selects which of two held register sets takes the word. With the flag at 0, the block decodes a 19-bit frame into an 11-bit main count and a 7-bit swallow count. With the flag at 1, it decodes a 16-bit frame into a 14-bit reference count and a 1-bit prescaler select.

All three serial lines are asynchronous to the system clock. They pass through a synchronizer, and the block finds their edges in the system-clock domain. A word whose count lies below its legal floor is refused: the held value stays as it was and a sticky error flag is set. A status output shows whether both register sets have taken a valid word since reset. The held fields drive the divider counters of a frequency synthesizer, which are outside this block.

Top module: `scl_loader`

## Requirements
- R1: After a synchronous reset (rst_n low at a clk edge), every held field is zero, cfg_err is 0 and not_configured is 1.
- R2: Routing flag 0 loads a divider frame. The bits are shifted in this order: main count bits 10..0, then swallow count bits 6..0, then the flag. main_cnt and swallow_cnt then show those values.
- R3: Routing flag 1 loads a reference frame. The bits are shifted in this order: prescaler select, then reference count bits 13..0, then the flag. presc_sel and ref_cnt then show those values.
- R4: The held fields change only after a rising edge of ser_le. Shifting bits without a strobe leaves every output as it was.
- R5: A divider frame leaves ref_cnt and presc_sel unchanged. A reference frame leaves main_cnt and swallow_cnt unchanged.
- R6: A reference frame with a count below 8 is refused. ref_cnt and presc_sel keep their old values and cfg_err becomes 1.
- R7: A divider frame with a main count below 16 is refused. main_cnt and swallow_cnt keep their old values and cfg_err becomes 1.
- R8: cfg_err stays 1 until the next reset.
- R9: not_configured stays 1 until both a divider frame and a reference frame have been accepted. After that it stays 0 until reset.
- R10: Only the last 19 bits (divider) or the last 16 bits (reference) before the strobe are used. Any bits shifted in earlier have no effect.
- R11: ser_data is sampled on the rising edge of ser_clk. A change on ser_data while ser_clk is high does not alter the captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Latch-enable strobe; a rising edge commits the word |
| swallow_cnt | output | 7 | Held swallow count |
| main_cnt | output | 11 | Held main count |
| ref_cnt | output | 14 | Held reference count |
| presc_sel | output | 1 | Held prescaler select |
| cfg_err | output | 1 | Sticky flag: a word was refused |
| not_configured | output | 1 | High until both register sets have been loaded |

## Verification
Assertions check on every cycle that:
- each register set stays stable unless a strobe routes a word to it;
- any held nonzero count meets its floor;
- the error and configured states never fall back before reset;
- the shift register moves by exactly one bit per detected serial edge.

Only the bench scenarios can show the end-to-end results:
- the bit order and field split of each frame type;
- that leading surplus bits are discarded;
- that a data change while the serial clock is high is ignored.

The bench sweeps every swallow value, the main and reference counts on both sides of their floors, and the largest reference count with both prescaler settings.

// File: rtl/scl_pkg.sv
// Package: shared widths, limits and held-word layouts for the serial
// control word loader. Assumes a main-count floor and a reference-count
// floor that fit in their fields.
package scl_pkg;
    localparam int SW_W     = 7;
    localparam int MAIN_W   = 11;
    localparam int REF_W    = 14;
    localparam int DIV_W    = SW_W + MAIN_W;
    localparam int REFL_W   = REF_W + 1;
    localparam int FRAME_W  = DIV_W + 1;
    localparam int MAIN_MIN = 16;
    localparam int REF_MIN  = 8;

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SW_W-1:0]   swallow;
    } div_word_t;

    typedef struct packed {
        logic             presc;
        logic [REF_W-1:0] count;
    } ref_word_t;
endpackage

// File: rtl/scl_sync_bus.sv
// Module: multi-stage synchronizer for a bundle of asynchronous lines.
// Assumes each line is stable far longer than STAGES clk periods, so the
// bits of the bundle cannot skew against each other in any way that matters.
module scl_sync_bus #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: move the bundle one synchronizer stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/scl_shifter.sv
// Module: serial-in shift register, newest bit in bit 0.
// Assumes shift_en is a one-cycle pulse for each serial clock rising edge.
module scl_shifter #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    // Purpose: shift one bit in on each detected serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], din};
        end
    end

    // R11 / R2: each serial edge moves the word exactly one place
    p_shift_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word == {$past(word[W-2:0]), $past(din)}));

    // R4: no serial edge, no change to the shifted word
    p_shift_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/scl_latch_bank.sv
// Module: decodes the routing flag and checks the count floors, then holds
// the divider and reference words. It also keeps the sticky error flag and
// the configured status.
// Assumes commit is a one-cycle pulse and word is stable during it.
module scl_latch_bank
    import scl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] word,
    output div_word_t          div_q,
    output ref_word_t          ref_q,
    output logic               err,
    output logic               unconfig
);
    logic      route_ref;
    div_word_t div_cand;
    ref_word_t ref_cand;
    logic      div_ok;
    logic      ref_ok;
    logic      div_seen;
    logic      ref_seen;

    // Purpose: split the shifted word into candidates and test the floors.
    always_comb begin
        route_ref = word[0];
        div_cand  = div_word_t'(word[DIV_W:1]);
        ref_cand  = ref_word_t'(word[REFL_W:1]);
        div_ok    = (div_cand.main >= MAIN_W'(MAIN_MIN));
        ref_ok    = (ref_cand.count >= REF_W'(REF_MIN));
    end

    // Purpose: update the divider register set on an accepted divider word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            div_seen <= 1'b0;
        end else if (commit && !route_ref && div_ok) begin
            div_q    <= div_cand;
            div_seen <= 1'b1;
        end
    end

    // Purpose: update the reference register set on an accepted reference word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q    <= '0;
            ref_seen <= 1'b0;
        end else if (commit && route_ref && ref_ok) begin
            ref_q    <= ref_cand;
            ref_seen <= 1'b1;
        end
    end

    // Purpose: set the sticky error flag on any refused word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (commit && ((route_ref && !ref_ok) || (!route_ref && !div_ok))) begin
            err <= 1'b1;
        end
    end

    assign unconfig = !(div_seen && ref_seen);

    // R4 / R5: the divider set moves only on a divider-routed strobe
    p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && !word[0]) |=> $stable(div_q));

    // R4 / R5: the reference set moves only on a reference-routed strobe
    p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && word[0]) |=> $stable(ref_q));

    // R7: a held divider word never has a main count below the floor
    p_main_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q != '0) |-> (div_q.main >= MAIN_W'(MAIN_MIN)));

    // R6: a held reference word never has a count below the floor
    p_ref_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q != '0) |-> (ref_q.count >= REF_W'(REF_MIN)));

    // R8: the error flag never clears without reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R9: once configured, the block stays configured and both sets are loaded
    p_cfg_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !unconfig |=> !unconfig);
    p_cfg_loaded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !unconfig |-> ((div_q != '0) && (ref_q != '0)));
endmodule

// File: rtl/scl_loader.sv
// Module: top of the serial control word loader. Synchronizes the three
// serial lines into clk, detects the serial clock and strobe rising edges,
// shifts data and commits the word to the routed register set.
// Assumes each serial line holds each level for more than STAGES+1 clk
// periods and that the strobe never rises together with the serial clock.
module scl_loader
    import scl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [SW_W-1:0]   swallow_cnt,
    output logic [MAIN_W-1:0] main_cnt,
    output logic [REF_W-1:0]  ref_cnt,
    output logic              presc_sel,
    output logic              cfg_err,
    output logic              not_configured
);
    localparam int LINES = 3;

    logic [LINES-1:0]   raw_lines;
    logic [LINES-1:0]   sync_lines;
    logic               sclk_prev;
    logic               le_prev;
    logic               shift_pulse;
    logic               commit_pulse;
    logic [FRAME_W-1:0] shift_word;
    div_word_t          div_q;
    ref_word_t          ref_q;

    assign raw_lines = {ser_le, ser_data, ser_clk};

    scl_sync_bus #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    // Purpose: keep the previous synchronized clock and strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            le_prev   <= 1'b0;
        end else begin
            sclk_prev <= sync_lines[0];
            le_prev   <= sync_lines[2];
        end
    end

    assign shift_pulse  = sync_lines[0] && !sclk_prev;
    assign commit_pulse = sync_lines[2] && !le_prev;

    scl_shifter #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_pulse),
        .din      (sync_lines[1]),
        .word     (shift_word)
    );

    scl_latch_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit_pulse),
        .word     (shift_word),
        .div_q    (div_q),
        .ref_q    (ref_q),
        .err      (cfg_err),
        .unconfig (not_configured)
    );

    assign swallow_cnt = div_q.swallow;
    assign main_cnt    = div_q.main;
    assign ref_cnt     = ref_q.count;
    assign presc_sel   = ref_q.presc;

    // R4: edge pulses are single-cycle
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> !commit_pulse);
endmodule

// File: tb/scl_loader_bench.sv
module scl_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_le = 1'b0;
    logic [6:0]  swallow_cnt;
    logic [10:0] main_cnt;
    logic [13:0] ref_cnt;
    logic        presc_sel;
    logic        cfg_err;
    logic        not_configured;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic [10:0] m_main = '0;
    logic [6:0]  m_sw   = '0;
    logic [13:0] m_ref  = '0;
    logic        m_ps   = 1'b0;
    logic        m_err  = 1'b0;
    bit          m_dseen = 0;
    bit          m_rseen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_loader u_scl_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
        .ref_cnt(ref_cnt), .presc_sel(presc_sel), .cfg_err(cfg_err),
        .not_configured(not_configured)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [34:0] act, exp;
        act = {main_cnt, swallow_cnt, presc_sel, ref_cnt, cfg_err, not_configured};
        exp = {m_main, m_sw, m_ps, m_ref, m_err, !(m_dseen && m_rseen)};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // shift one bit; glitch flips the data while the serial clock is high
    task automatic send_bit(input logic b, input bit glitch);
        ser_data = b;
        wait_clk(PH);
        ser_clk = 1'b1;
        wait_clk(PH);
        if (glitch) ser_data = ~b;
        wait_clk(PH);
        ser_clk = 1'b0;
        wait_clk(PH);
    endtask

    task automatic strobe();
        wait_clk(PH);
        ser_le = 1'b1;
        wait_clk(PH);
        ser_le = 1'b0;
        wait_clk(PH + 2);
    endtask

    task automatic send_div(input logic [10:0] mn, input logic [6:0] sw,
                            input bit glitch, input string tag);
        logic [18:0] f;
        f = {mn, sw, 1'b0};
        for (int i = 18; i >= 0; i--) send_bit(f[i], glitch);
        check_all("R4 no change before strobe");
        strobe();
        if (mn >= 16) begin
            m_main = mn; m_sw = sw; m_dseen = 1;
        end else begin
            m_err = 1'b1;
        end
        check_all(tag);
    endtask

    task automatic send_ref(input logic ps, input logic [13:0] cnt,
                            input bit glitch, input string tag);
        logic [15:0] f;
        f = {ps, cnt, 1'b1};
        for (int i = 15; i >= 0; i--) send_bit(f[i], glitch);
        check_all("R4 no change before strobe");
        strobe();
        if (cnt >= 8) begin
            m_ref = cnt; m_ps = ps; m_rseen = 1;
        end else begin
            m_err = 1'b1;
        end
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        m_main = '0; m_sw = '0; m_ref = '0; m_ps = 1'b0; m_err = 1'b0;
        m_dseen = 0; m_rseen = 0;
        wait_clk(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_all("R1 reset state");

        // R9: divider alone leaves block unconfigured
        send_div(11'd100, 7'd3, 0, "R2 R9 first divider");
        send_ref(1'b1, 14'd500, 0, "R3 R9 first reference");

        // R2: every swallow value with varied main counts
        for (int s = 0; s < 128; s++)
            send_div(11'(16 + (s * 13) % 2032), 7'(s), 0, "R2 swallow sweep");
        // R2: main count at and above the floor, plus the top
        for (int m = 16; m <= 24; m++)
            send_div(11'(m), 7'(m), 0, "R2 main sweep");
        send_div(11'd2047, 7'd127, 0, "R2 main max");

        // R3: reference count at and above the floor, top, both selects
        for (int c = 8; c <= 20; c++)
            send_ref(1'(c & 1), 14'(c), 0, "R3 ref sweep");
        send_ref(1'b0, 14'd16383, 0, "R3 ref max sel0");
        send_ref(1'b1, 14'd16383, 0, "R3 ref max sel1");

        // R5: cross-routing leaves the other set alone
        send_div(11'd777, 7'd55, 0, "R5 divider keeps reference");
        send_ref(1'b0, 14'd1234, 0, "R5 reference keeps divider");

        // R10: surplus leading bits discarded
        for (int k = 0; k < 7; k++) send_bit(1'b1, 0);
        send_ref(1'b0, 14'd9, 0, "R10 leading bits ref");
        for (int k = 0; k < 5; k++) send_bit(1'b1, 0);
        send_div(11'd16, 7'd0, 0, "R10 leading bits div");

        // R11: data changes while serial clock high are ignored
        send_div(11'h2A5, 7'h35, 1, "R11 glitch divider");
        send_ref(1'b1, 14'h15A5, 1, "R11 glitch reference");

        // R7 / R8: main count below floor refused, error sticky
        for (int m = 0; m < 16; m++)
            send_div(11'(m), 7'h7F, 0, "R7 R8 main below floor");
        send_div(11'd300, 7'd9, 0, "R8 error stays after good divider");
        // R6: reference count below floor refused
        for (int c = 0; c < 8; c++)
            send_ref(1'(~c & 1), 14'(c), 0, "R6 ref below floor");

        // R8 / R1: reset clears the error and the held words
        do_reset();
        check_all("R1 R8 reset clears error");
        send_ref(1'b1, 14'd3, 0, "R6 R9 refused ref from reset");
        send_div(11'd5, 7'd1, 0, "R7 R9 refused div from reset");
        send_ref(1'b1, 14'd8, 0, "R6 R9 ref floor accepted");
        send_div(11'd16, 7'd0, 0, "R7 R9 main floor accepted");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule